// File: doc/BRIEF.md
# Output-Enable and Range-Change Sequencer

This block is a control state machine that brings a four-channel analog output converter up without output glitches. Later it changes the output range of one channel. It talks to the converter only through a request/acknowledge register-write port, which carries an address and a data word. A serial link outside the block turns each write into a frame.

A start-up request sends these writes in order:
- a reset command;
- the configuration word for the shared switching supply;
- for each channel in turn, starting with channel 0:
  - a control word with the output still disabled;
  - the initial data code;
  - after a settling wait, the same control word with the output enabled.

A range-change request covers one channel. It first parks that channel's output at its zero code. It then disables the output while selecting the new range, writes the new code, waits, and enables the output again. The settling wait is measured with a microsecond tick that is derived from the clock frequency parameter.

Top module: `outen_seq`

## Requirements
- R1: After reset, `wr_req`, `busy`, `done` and `err` are low, and no write is issued until a request arrives.
- R2: A start-up sequence begins with a write of `RESET_KEY` to address kind 0, channel 0. The next write is `SUPPLY_CFG` to address kind 1, channel 0.
- R3: After those two writes, start-up handles channels 0 to `NCH-1` in ascending order. Each channel gets three writes: control with the output off, data `init_code`, and control with the output on. That makes 2 + 3·NCH writes in total.
- R4: A control word holds the range in bits [RNG_W-1:0], supply-enable in bit 4, internal-enable in bit 5 and output-enable in bit 6. Bits 4 and 5 are always 1 and every other bit is 0.
- R5: Every write whose control word has output-enable set is requested no earlier than `CLK_MHZ*SETTLE_US` cycles after the acknowledge of the data write before it. This holds in both flows.
- R6: A range change issues exactly four writes to the chosen channel: the zero code, control with the output off and the new range, the new code, and control with the output on. It never writes the supply configuration. The zero code is 0x8000 when the range MSB is 1 (bipolar) and 0x0000 when it is 0.
- R7: `wr_req` stays high with stable `wr_addr` and `wr_data` until `wr_ack` is seen. It is low in the cycle after the acknowledge.
- R8: `busy` rises in the cycle after an accepted request and falls with the acknowledge of the final write. `done` is a one-cycle pulse in that same cycle. `wr_req` is only high while `busy` is high.
- R9: In each of these cases `err` pulses for one cycle and no write is issued: a range change before the first start-up has completed, any request while a sequence is running, or a range change in the same cycle as a start-up request.
- R10: The write address is {kind[1:0], channel[CH_W-1:0]}. Kind 0 is reset, 1 is supply configuration, 2 is control and 3 is data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start-up request pulse |
| init_range | input | RNG_W | Range used for all channels at start-up |
| init_code | input | DATA_W | Data code written to all channels at start-up |
| chg_req | input | 1 | Range-change request pulse |
| chg_chan | input | CH_W | Channel to reprogram |
| chg_range | input | RNG_W | New range code |
| chg_code | input | DATA_W | New data code |
| wr_req | output | 1 | Write request |
| wr_addr | output | 2+CH_W | Write address {kind, channel} |
| wr_data | output | DATA_W | Write data |
| wr_ack | input | 1 | Write acknowledge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished pulse |
| err | output | 1 | Rejected request pulse |

## Verification
The bench sweeps every channel against every range code, and its write-port model varies the acknowledge latency. The sweep exposes several failure modes:
- A decoder with a wrong midscale or range-bit position would emit the wrong zero code.
- A design that skipped the settle wait in the range-change flow, or counted it from the wrong write, would request output-enable too early.
- A design that recycled the start-up path for range changes would emit a stray supply write.

The bench also probes the rejection cases: a range change before start-up, a request in the middle of a sequence, and simultaneous requests. A sequencer that queued or accepted any of these would show extra writes or a missing error pulse.

// File: rtl/outen_seq_pkg.sv
package outen_seq_pkg;
  typedef enum logic [1:0] {K_RST = 2'd0, K_SUP = 2'd1, K_CTL = 2'd2, K_DAT = 2'd3} kind_e;
  typedef enum logic [2:0] {OP_RESET, OP_SUPPLY, OP_CTL_OFF, OP_DATA, OP_SETTLE, OP_CTL_ON, OP_ZERO} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_ISSUE, ST_SETTLE} st_e;
  localparam int B_SUP = 4;
  localparam int B_INT = 5;
  localparam int B_OUT = 6;
endpackage

// File: rtl/outen_seq_step.sv
module outen_seq_step
  import outen_seq_pkg::*;
(
  input  op_e  op,
  input  logic chg_mode,
  input  logic last_ch,
  output op_e  nxt,
  output logic ch_inc,
  output logic last
);
  always_comb begin
    nxt    = op;
    ch_inc = 1'b0;
    last   = 1'b0;
    case (op)
      OP_RESET:   nxt = OP_SUPPLY;
      OP_SUPPLY:  nxt = OP_CTL_OFF;
      OP_ZERO:    nxt = OP_CTL_OFF;
      OP_CTL_OFF: nxt = OP_DATA;
      OP_DATA:    nxt = OP_SETTLE;
      OP_CTL_ON: begin
        if (chg_mode || last_ch) last = 1'b1;
        else begin
          nxt    = OP_CTL_OFF;
          ch_inc = 1'b1;
        end
      end
      default:    nxt = op;
    endcase
  end
endmodule

// File: rtl/outen_seq_fmt.sv
module outen_seq_fmt
  import outen_seq_pkg::*;
#(
  parameter int CH_W   = 2,
  parameter int DATA_W = 16,
  parameter int RNG_W  = 3,
  parameter logic [DATA_W-1:0] RESET_KEY  = 16'h0001,
  parameter logic [DATA_W-1:0] SUPPLY_CFG = 16'h0257
) (
  input  op_e               op,
  input  logic [CH_W-1:0]   chan,
  input  logic [RNG_W-1:0]  rng,
  input  logic [DATA_W-1:0] code,
  output logic [CH_W+1:0]   addr,
  output logic [DATA_W-1:0] data
);
  kind_e kind;
  logic [CH_W-1:0] ch;

  always_comb begin
    kind = K_DAT;
    ch   = chan;
    data = code;
    case (op)
      OP_RESET: begin
        kind = K_RST;
        ch   = '0;
        data = RESET_KEY;
      end
      OP_SUPPLY: begin
        kind = K_SUP;
        ch   = '0;
        data = SUPPLY_CFG;
      end
      OP_CTL_OFF, OP_CTL_ON: begin
        kind = K_CTL;
        data = '0;
        data[RNG_W-1:0] = rng;
        data[B_SUP] = 1'b1;
        data[B_INT] = 1'b1;
        data[B_OUT] = (op == OP_CTL_ON);
      end
      OP_ZERO: begin
        data = '0;
        data[DATA_W-1] = rng[RNG_W-1];
      end
      default: data = code;
    endcase
    addr = {kind, ch};
  end
endmodule

// File: rtl/outen_seq_timer.sv
module outen_seq_timer #(
  parameter int CLK_MHZ   = 100,
  parameter int SETTLE_US = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic expired
);
  localparam int PW = $clog2(CLK_MHZ + 1);
  localparam int UW = $clog2(SETTLE_US + 1);

  logic [PW-1:0] pre;
  logic [UW-1:0] us;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '0;
      us  <= '0;
    end else if (go) begin
      pre <= PW'(CLK_MHZ - 1);
      us  <= UW'(SETTLE_US);
    end else if (us != '0) begin
      if (pre == '0) begin
        pre <= PW'(CLK_MHZ - 1);
        us  <= us - 1'b1;
      end else begin
        pre <= pre - 1'b1;
      end
    end
  end

  assign expired = (us == '0);
endmodule

// File: rtl/outen_seq.sv
module outen_seq
  import outen_seq_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int SETTLE_US = 200,
  parameter int NCH       = 4,
  parameter int DATA_W    = 16,
  parameter int RNG_W     = 3,
  parameter logic [DATA_W-1:0] RESET_KEY  = 16'h0001,
  parameter logic [DATA_W-1:0] SUPPLY_CFG = 16'h0257,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic [RNG_W-1:0]  init_range,
  input  logic [DATA_W-1:0] init_code,
  input  logic              chg_req,
  input  logic [CH_W-1:0]   chg_chan,
  input  logic [RNG_W-1:0]  chg_range,
  input  logic [DATA_W-1:0] chg_code,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              busy,
  output logic              done,
  output logic              err
);
  st_e               st;
  op_e               op;
  op_e               nxt;
  logic              chg_mode;
  logic              up;
  logic [CH_W-1:0]   chan;
  logic [RNG_W-1:0]  rng;
  logic [DATA_W-1:0] code;
  logic              ch_inc, last, expired, tmr_go;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data;

  outen_seq_step u_step (
    .op(op), .chg_mode(chg_mode), .last_ch(chan == CH_W'(NCH - 1)),
    .nxt(nxt), .ch_inc(ch_inc), .last(last)
  );

  outen_seq_fmt #(
    .CH_W(CH_W), .DATA_W(DATA_W), .RNG_W(RNG_W),
    .RESET_KEY(RESET_KEY), .SUPPLY_CFG(SUPPLY_CFG)
  ) u_fmt (
    .op(op), .chan(chan), .rng(rng), .code(code), .addr(f_addr), .data(f_data)
  );

  assign tmr_go = (st == ST_ISSUE) && wr_ack && !last && (nxt == OP_SETTLE);

  outen_seq_timer #(.CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US)) u_tmr (
    .clk(clk), .rst(rst), .go(tmr_go), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      op       <= OP_RESET;
      chg_mode <= 1'b0;
      up       <= 1'b0;
      chan     <= '0;
      rng      <= '0;
      code     <= '0;
      wr_req   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_req) begin
            chg_mode <= 1'b0;
            op       <= OP_RESET;
            chan     <= '0;
            rng      <= init_range;
            code     <= init_code;
            busy     <= 1'b1;
            st       <= ST_GAP;
            if (chg_req) err <= 1'b1;
          end else if (chg_req) begin
            if (up) begin
              chg_mode <= 1'b1;
              op       <= OP_ZERO;
              chan     <= chg_chan;
              rng      <= chg_range;
              code     <= chg_code;
              busy     <= 1'b1;
              st       <= ST_GAP;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_GAP: begin
          wr_req  <= 1'b1;
          wr_addr <= f_addr;
          wr_data <= f_data;
          st      <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (wr_ack) begin
            wr_req <= 1'b0;
            if (last) begin
              busy <= 1'b0;
              done <= 1'b1;
              st   <= ST_IDLE;
              if (!chg_mode) up <= 1'b1;
            end else if (nxt == OP_SETTLE) begin
              op <= OP_SETTLE;
              st <= ST_SETTLE;
            end else begin
              op   <= nxt;
              chan <= chan + CH_W'(ch_inc);
              st   <= ST_GAP;
            end
          end
        end
        ST_SETTLE: begin
          if (expired) begin
            op <= OP_CTL_ON;
            st <= ST_GAP;
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (st != ST_IDLE && (start_req || chg_req)) err <= 1'b1;
    end
  end
endmodule

// File: rtl/outen_seq_chk.sv
module outen_seq_chk #(
  parameter int CLK_MHZ   = 100,
  parameter int SETTLE_US = 200,
  parameter int CH_W      = 2,
  parameter int DATA_W    = 16,
  parameter int RNG_W     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_req,
  input logic [CH_W+1:0]   wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_ack,
  input logic              busy,
  input logic              done
);
  localparam int MIN_CYC = CLK_MHZ * SETTLE_US;
  logic [31:0] since_data;

  always_ff @(posedge clk) begin
    if (rst) since_data <= '0;
    else if (wr_req && wr_ack && wr_addr[CH_W+1:CH_W] == 2'd3) since_data <= '0;
    else if (since_data != 32'hFFFF_FFFF) since_data <= since_data + 1'b1;
  end

  p_settle_gap_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(wr_req) && wr_addr[CH_W+1:CH_W] == 2'd2 && wr_data[6]) |-> (since_data >= MIN_CYC));

  p_hold_until_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  p_drop_after_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_req && wr_ack) |=> !wr_req);

  p_req_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> busy);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_ctl_bits_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_req && wr_addr[CH_W+1:CH_W] == 2'd2) |->
      (wr_data[4] && wr_data[5] && wr_data[3:RNG_W] == '0 && wr_data[DATA_W-1:7] == '0));
endmodule

bind outen_seq outen_seq_chk #(
  .CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US), .CH_W(CH_W), .DATA_W(DATA_W), .RNG_W(RNG_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_ack(wr_ack), .busy(busy), .done(done)
);

// File: tb/outen_seq_tb.sv
module outen_seq_tb;
  localparam int CLK_MHZ = 2;
  localparam int SETTLE_US = 3;
  localparam int MIN = CLK_MHZ * SETTLE_US;
  localparam int NCH = 4;
  localparam logic [15:0] RKEY = 16'h5A01;
  localparam logic [15:0] SCFG = 16'h0C37;

  logic clk = 0, rst = 1;
  logic start_req = 0, chg_req = 0, wr_ack = 0;
  logic [2:0] init_range = 0, chg_range = 0;
  logic [15:0] init_code = 0, chg_code = 0;
  logic [1:0] chg_chan = 0;
  logic wr_req, busy, done, err;
  logic [3:0] wr_addr;
  logic [15:0] wr_data;

  always #4 clk = ~clk;

  outen_seq #(.CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US), .NCH(NCH), .DATA_W(16), .RNG_W(3),
              .RESET_KEY(RKEY), .SUPPLY_CFG(SCFG)) u_dut (
    .clk(clk), .rst(rst), .start_req(start_req), .init_range(init_range), .init_code(init_code),
    .chg_req(chg_req), .chg_chan(chg_chan), .chg_range(chg_range), .chg_code(chg_code),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .busy(busy), .done(done), .err(err));

  int total = 0, bad = 0;
  int cyc = 0, nlog = 0, v_hold = 0, v_drop = 0, wcnt = 0, tq = 0;
  logic pend = 0, chk_drop = 0;
  logic [3:0] pa;
  logic [15:0] pd;
  logic [3:0] la [256];
  logic [15:0] ld [256];
  int lt [256];
  int lq [256];

  // write-port model with latency 0..2 cycles
  always @(posedge clk) begin
    cyc <= cyc + 1;
    chk_drop <= wr_ack;
    if (chk_drop && wr_req) v_drop <= v_drop + 1;
    if (rst) begin
      wr_ack <= 0;
      pend <= 0;
    end else if (wr_ack) begin
      wr_ack <= 0;
    end else if (wr_req) begin
      if (!pend) begin
        pend <= 1; tq <= cyc; wcnt <= 0; pa <= wr_addr; pd <= wr_data;
      end else begin
        if (pa != wr_addr || pd != wr_data) v_hold <= v_hold + 1;
        if (wcnt >= nlog % 3) begin
          wr_ack <= 1; pend <= 0;
          la[nlog[7:0]] <= wr_addr; ld[nlog[7:0]] <= wr_data;
          lq[nlog[7:0]] <= tq; lt[nlog[7:0]] <= cyc;
          nlog <= nlog + 1;
        end else wcnt <= wcnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input logic [2:0] r, input bit on);
    return 16'h0030 | (on ? 16'h0040 : 16'h0) | {13'b0, r};
  endfunction

  task automatic chk_wr(input int i, input logic [3:0] ea, input logic [15:0] ed, input string req);
    check(la[i] == ea, req, "address", la[i], ea);
    check(ld[i] == ed, req, "data", ld[i], ed);
  endtask

  task automatic chk_gap(input int i, input string req);
    int g = lq[i] - lt[i-1];
    check(g >= MIN && g <= MIN + 8, req, "settle gap", g, MIN);
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 4000) begin @(negedge clk); n++; end
    check(done == 1, req, "done seen", done, 1);
    check(busy == 0, "R8", "busy low at done", busy, 0);
    @(negedge clk);
    check(done == 0, "R8", "done one cycle", done, 0);
  endtask

  task automatic startup(input logic [2:0] r, input logic [15:0] c);
    int base = nlog;
    @(negedge clk); init_range = r; init_code = c; start_req = 1;
    @(negedge clk); start_req = 0;
    check(busy == 1, "R8", "busy after start", busy, 1);
    check(err == 0, "R9", "no err on start", err, 0);
    wait_done("R3");
    check(nlog - base == 2 + 3 * NCH, "R3", "write count", nlog - base, 2 + 3 * NCH);
    chk_wr(base, 4'h0, RKEY, "R2");
    chk_wr(base + 1, 4'h4, SCFG, "R2");
    for (int ch = 0; ch < NCH; ch++) begin
      chk_wr(base + 2 + 3 * ch, 4'(8 + ch), cw(r, 0), "R4");
      chk_wr(base + 3 + 3 * ch, 4'(12 + ch), c, "R10");
      chk_wr(base + 4 + 3 * ch, 4'(8 + ch), cw(r, 1), "R3");
      chk_gap(base + 4 + 3 * ch, "R5");
    end
  endtask

  task automatic range_change(input logic [1:0] ch, input logic [2:0] r, input logic [15:0] c);
    int base = nlog;
    @(negedge clk); chg_chan = ch; chg_range = r; chg_code = c; chg_req = 1;
    @(negedge clk); chg_req = 0;
    check(busy == 1 && err == 0, "R8", "accepted change", {busy, err}, 2);
    wait_done("R6");
    check(nlog - base == 4, "R6", "change write count", nlog - base, 4);
    chk_wr(base, 4'(12 + ch), r[2] ? 16'h8000 : 16'h0000, "R6");
    chk_wr(base + 1, 4'(8 + ch), cw(r, 0), "R6");
    chk_wr(base + 2, 4'(12 + ch), c, "R6");
    chk_wr(base + 3, 4'(8 + ch), cw(r, 1), "R6");
    chk_gap(base + 3, "R5");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R1", "watchdog expired", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(wr_req == 0 && busy == 0 && done == 0 && err == 0, "R1", "reset outputs",
          {wr_req, busy, done, err}, 0);
    repeat (20) @(negedge clk);
    check(nlog == 0, "R1", "idle writes", nlog, 0);

    // change before start-up: rejected
    @(negedge clk); chg_chan = 1; chg_range = 3; chg_req = 1;
    @(negedge clk); chg_req = 0;
    check(err == 1 && busy == 0, "R9", "early change err", {err, busy}, 2);
    @(negedge clk);
    check(err == 0, "R9", "err one cycle", err, 0);
    repeat (10) @(negedge clk);
    check(nlog == 0, "R9", "no writes after early change", nlog, 0);

    startup(3'd5, 16'h1234);

    // request in mid-sequence: rejected, sequence unchanged
    base = nlog;
    @(negedge clk); init_range = 3'd2; init_code = 16'hBEEF; start_req = 1;
    @(negedge clk); start_req = 0;
    repeat (5) @(negedge clk);
    chg_chan = 2; chg_range = 7; chg_req = 1;
    @(negedge clk); chg_req = 0;
    check(err == 1, "R9", "change while busy err", err, 1);
    wait_done("R9");
    check(nlog - base == 2 + 3 * NCH, "R9", "busy reject writes", nlog - base, 2 + 3 * NCH);
    chk_wr(base + 4 + 3 * (NCH - 1), 4'(8 + NCH - 1), cw(3'd2, 1), "R9");

    // simultaneous requests: start wins, change errs
    base = nlog;
    @(negedge clk); init_range = 3'd1; init_code = 16'h0F0F; start_req = 1; chg_req = 1;
    @(negedge clk); start_req = 0; chg_req = 0;
    check(err == 1 && busy == 1, "R9", "simultaneous err", {err, busy}, 3);
    wait_done("R9");
    check(nlog - base == 2 + 3 * NCH, "R9", "simultaneous writes", nlog - base, 2 + 3 * NCH);

    for (int ch = 0; ch < NCH; ch++)
      for (int r = 0; r < 8; r++)
        range_change(2'(ch), 3'(r), 16'(ch * 16'h1111 + r * 16'h0203 + 16'h0100));

    check(v_hold == 0, "R7", "request held stable", v_hold, 0);
    check(v_drop == 0, "R7", "request drop after ack", v_drop, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule